// File: doc/BRIEF.md
# Vector Context Save/Restore Sequencer

This block moves the architectural state of a vector unit between its live storage and a packed memory image, so that an exception handler can park a vector context and bring it back later. A single command gives a base byte address and a direction. The block then steps through a fixed image one item per memory beat. In save direction it gathers values from the control-register inputs, the integer and floating-point register files, and the per-element run flags. In restore direction it reads the same image back and pushes each item to the matching write port.

The image has a fixed shape. It opens with a header of five 32-bit words and four bytes of padding, followed by the 64-bit fetch address of the vector program. Next comes the element data, laid out one register at a time, and last comes one byte for each active element. The loop bounds for the data sections are the register counts and the vector length. On save they are captured when the command is taken. On restore they are taken from the header words as they come back, so the image describes its own size.

Only a command issued with the privilege input high is started. A command without privilege is refused for that cycle and has no other effect.

Top module: `vctx_xfer`

## Requirements
- R1: A command (`cmd_valid` high while idle) starts a transfer only if `priv_ok` is high. With `priv_ok` low, `cmd_refused` is high in that same cycle, `busy` stays low and no memory request is made.
- R2: The first five items are 32-bit words (`mem_size` = 1) at base+0, +4, +8, +12 and +16. In that order they hold the integer register count, the floating-point register count, the maximum vector length, the current vector length and the current element index. Bytes base+20 to +23 are never accessed.
- R3: The sixth item is the 64-bit vector fetch address (`mem_size` = 2) at base+24.
- R4: From base+32, integer registers 1 to count−1 follow as 64-bit items, register-major: every element 0 to vl−1 of one register before the next register. Register 0 is never transferred.
- R5: Floating-point registers 0 to count−1 follow directly after the integer data, in the same register-major order and also as 64-bit items.
- R6: The image ends with one byte (`mem_size` = 0) per element 0 to vl−1. Bit 0 of each byte is that element's run flag and the other bits are written as zero.
- R7: On restore, header words go to `ctl_we` with `ctl_sel` 0–4 in header order and the fetch address goes out with `ctl_sel` 5. Data items go out through `rf_we`, and run bytes go out through `run_we`. The data-section bounds are the restored header values, not the values held before the restore.
- R8: Empty sections produce no beats. With vl = 0 the transfer ends after the fetch address. With integer count ≤ 1 the integer section is skipped, and with floating-point count 0 that section is skipped.
- R9: The request holds its address, size and data until `mem_ready` is seen. Each accepted beat advances the address by the item size (1, 4 or 8), plus 4 more after the fifth header word.
- R10: `busy` is high from the accepted command until the cycle of the one-cycle `done` pulse, and it drops in the cycle after `done`. Commands that arrive while busy are ignored.
- R11: On save, each register-file item is read by a one-cycle `rf_re` strobe. The data returned one cycle later (and held by the file until its next strobe) is the value written to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_restore | input | 1 | 1 = restore from memory, 0 = save to memory |
| cmd_base | input | AW | Image base byte address |
| priv_ok | input | 1 | Issuer holds supervisor privilege |
| cmd_refused | output | 1 | Command refused for lack of privilege |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last beat |
| cur_nxpr | input | 32 | Live integer register count |
| cur_nfpr | input | 32 | Live floating-point register count |
| cur_maxvl | input | 32 | Live maximum vector length |
| cur_vl | input | 32 | Live vector length |
| cur_idx | input | 32 | Live element index |
| cur_pc | input | 64 | Live vector fetch address |
| ctl_we | output | 1 | Control-register write strobe (restore) |
| ctl_sel | output | 3 | Control register select, 0–4 header order, 5 fetch address |
| ctl_wdata | output | 64 | Control write data |
| rf_re | output | 1 | Register-file read strobe |
| rf_we | output | 1 | Register-file write strobe |
| rf_fp | output | 1 | 1 = floating-point file, 0 = integer file |
| rf_reg | output | RW | Register number |
| rf_elem | output | EW | Element number |
| rf_wdata | output | 64 | Register-file write data |
| rf_rdata | input | 64 | Register-file read data, one-cycle latency |
| run_flags | input | MAXVL | Live per-element run flags |
| run_we | output | 1 | Run flag write strobe |
| run_elem | output | EW | Run flag element |
| run_wval | output | 1 | Run flag value |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_size | output | 2 | 0 byte, 1 word, 2 doubleword |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 64 | Store data, little-endian, right-aligned |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | 64 | Load data, right-aligned, valid with ready |

## Verification
The bench builds the block with eight registers per file, a maximum vector length of four and a 16-bit address. At that size a full register file and a full vector can be exercised in a few hundred cycles, and so can the element-index boundary. The other cases covered are a single-register integer file, an empty floating-point file and a zero vector length. A restore whose header is smaller than the live state checks that the bounds come from the image, and a randomly stalling memory keeps each request held for a varying number of cycles.

// File: rtl/vctx_pkg.sv
package vctx_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2
   } xfer_size_e;

   typedef enum logic [2:0] {
      SEC_HDR,
      SEC_PC,
      SEC_XPR,
      SEC_FPR,
      SEC_RUN,
      SEC_END
   } section_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RFRD,
      ST_MEM,
      ST_FIN
   } state_e;

   localparam int unsigned HDR_WORDS = 5;
   localparam int unsigned HDR_PAD   = 4;
   localparam logic [2:0]  SEL_PC    = 3'd5;

   function automatic logic [3:0] size_bytes(xfer_size_e s);
      case (s)
         SZ_BYTE:  return 4'd1;
         SZ_WORD:  return 4'd4;
         default:  return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/vctx_walker.sv
module vctx_walker
   import vctx_pkg::*;
#(
   parameter int unsigned CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          step,
   input  logic [CW-1:0] nxpr,
   input  logic [CW-1:0] nfpr,
   input  logic [CW-1:0] vl,
   output section_e      sect,
   output logic [CW-1:0] idx,
   output logic [CW-1:0] elem,
   output section_e      nsect,
   output logic          last_hdr
);

   section_e      sect_q;
   logic [CW-1:0] idx_q, elem_q;
   logic [CW-1:0] nidx, nelem;
   logic          xpr_ok, fpr_ok, run_ok, elem_wrap;

   assign run_ok    = (vl != '0);
   assign xpr_ok    = run_ok && (nxpr > CW'(1));
   assign fpr_ok    = run_ok && (nfpr != '0);
   assign elem_wrap = !((elem_q + CW'(1)) < vl);
   assign last_hdr  = (sect_q == SEC_HDR) && (idx_q == CW'(HDR_WORDS - 1));

   always_comb begin
      nsect = sect_q;
      nidx  = idx_q;
      nelem = elem_q;
      case (sect_q)
         SEC_HDR: begin
            if (last_hdr) begin
               nsect = SEC_PC;
               nidx  = '0;
            end else begin
               nidx = idx_q + CW'(1);
            end
         end
         SEC_PC: begin
            nelem = '0;
            if (xpr_ok) begin
               nsect = SEC_XPR;
               nidx  = CW'(1);
            end else if (fpr_ok) begin
               nsect = SEC_FPR;
               nidx  = '0;
            end else if (run_ok) begin
               nsect = SEC_RUN;
               nidx  = '0;
            end else begin
               nsect = SEC_END;
            end
         end
         SEC_XPR, SEC_FPR: begin
            if (!elem_wrap) begin
               nelem = elem_q + CW'(1);
            end else begin
               nelem = '0;
               if ((idx_q + CW'(1)) < ((sect_q == SEC_XPR) ? nxpr : nfpr)) begin
                  nidx = idx_q + CW'(1);
               end else if ((sect_q == SEC_XPR) && fpr_ok) begin
                  nsect = SEC_FPR;
                  nidx  = '0;
               end else begin
                  nsect = SEC_RUN;
                  nidx  = '0;
               end
            end
         end
         SEC_RUN: begin
            if (!elem_wrap) nelem = elem_q + CW'(1);
            else            nsect = SEC_END;
         end
         default: nsect = SEC_END;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sect_q <= SEC_END;
         idx_q  <= '0;
         elem_q <= '0;
      end else if (start) begin
         sect_q <= SEC_HDR;
         idx_q  <= '0;
         elem_q <= '0;
      end else if (step) begin
         sect_q <= nsect;
         idx_q  <= nidx;
         elem_q <= nelem;
      end
   end

   assign sect = sect_q;
   assign idx  = idx_q;
   assign elem = elem_q;

endmodule

// File: rtl/vctx_addr_acc.sv
module vctx_addr_acc #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   input  logic [3:0]    inc,
   output logic [AW-1:0] addr
);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= base;
      else if (adv)  addr_q <= addr_q + {{(AW-4){1'b0}}, inc};
   end

   assign addr = addr_q;

endmodule

// File: rtl/vctx_xfer.sv
module vctx_xfer
   import vctx_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned NREG  = 32,
   parameter int unsigned MAXVL = 8,
   localparam int unsigned RW   = $clog2(NREG),
   localparam int unsigned EW   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_restore,
   input  logic [AW-1:0]    cmd_base,
   input  logic             priv_ok,
   output logic             cmd_refused,
   output logic             busy,
   output logic             done,
   input  logic [31:0]      cur_nxpr,
   input  logic [31:0]      cur_nfpr,
   input  logic [31:0]      cur_maxvl,
   input  logic [31:0]      cur_vl,
   input  logic [31:0]      cur_idx,
   input  logic [63:0]      cur_pc,
   output logic             ctl_we,
   output logic [2:0]       ctl_sel,
   output logic [63:0]      ctl_wdata,
   output logic             rf_re,
   output logic             rf_we,
   output logic             rf_fp,
   output logic [RW-1:0]    rf_reg,
   output logic [EW-1:0]    rf_elem,
   output logic [63:0]      rf_wdata,
   input  logic [63:0]      rf_rdata,
   input  logic [MAXVL-1:0] run_flags,
   output logic             run_we,
   output logic [EW-1:0]    run_elem,
   output logic             run_wval,
   output logic             mem_valid,
   output logic             mem_write,
   output logic [1:0]       mem_size,
   output logic [AW-1:0]    mem_addr,
   output logic [63:0]      mem_wdata,
   input  logic             mem_ready,
   input  logic [63:0]      mem_rdata
);

   localparam int unsigned CW = 32;

   if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_nreg
      $error("vctx_xfer: NREG must be a power of two of at least 2");
   end
   if (MAXVL < 2 || (1 << EW) != MAXVL) begin : g_bad_maxvl
      $error("vctx_xfer: MAXVL must be a power of two of at least 2");
   end
   if (AW < 8) begin : g_bad_aw
      $error("vctx_xfer: AW must be at least 8");
   end

   state_e        state_q;
   logic          dir_q;
   logic [CW-1:0] nxpr_q, nfpr_q, vl_q;

   section_e      sect, nsect;
   logic [CW-1:0] idx, elem;
   logic          last_hdr;
   logic          accept, fire, is_rf;
   xfer_size_e    size;
   logic [3:0]    inc;
   logic [63:0]   hdr_word;

   assign accept      = cmd_valid && (state_q == ST_IDLE) && priv_ok;
   assign cmd_refused = cmd_valid && (state_q == ST_IDLE) && !priv_ok;
   assign mem_valid   = (state_q == ST_MEM);
   assign fire        = mem_valid && mem_ready;
   assign busy        = (state_q != ST_IDLE);
   assign done        = (state_q == ST_FIN);
   assign is_rf       = (sect == SEC_XPR) || (sect == SEC_FPR);

   vctx_walker #(.CW(CW)) walk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .step     (fire),
      .nxpr     (nxpr_q),
      .nfpr     (nfpr_q),
      .vl       (vl_q),
      .sect     (sect),
      .idx      (idx),
      .elem     (elem),
      .nsect    (nsect),
      .last_hdr (last_hdr)
   );

   always_comb begin
      case (sect)
         SEC_HDR: size = SZ_WORD;
         SEC_RUN: size = SZ_BYTE;
         default: size = SZ_DWORD;
      endcase
   end

   assign inc = size_bytes(size) + (last_hdr ? 4'(HDR_PAD) : 4'd0);

   vctx_addr_acc #(.AW(AW)) addr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .base  (cmd_base),
      .adv   (fire),
      .inc   (inc),
      .addr  (mem_addr)
   );

   always_comb begin
      case (idx[2:0])
         3'd0:    hdr_word = {32'b0, cur_nxpr};
         3'd1:    hdr_word = {32'b0, cur_nfpr};
         3'd2:    hdr_word = {32'b0, cur_maxvl};
         3'd3:    hdr_word = {32'b0, cur_vl};
         default: hdr_word = {32'b0, cur_idx};
      endcase
   end

   always_comb begin
      case (sect)
         SEC_HDR: mem_wdata = hdr_word;
         SEC_PC:  mem_wdata = cur_pc;
         SEC_RUN: mem_wdata = {63'b0, run_flags[elem[EW-1:0]]};
         default: mem_wdata = rf_rdata;
      endcase
   end

   assign mem_write = !dir_q;
   assign mem_size  = size;

   assign rf_re     = (state_q == ST_RFRD);
   assign rf_we     = fire && dir_q && is_rf;
   assign rf_fp     = (sect == SEC_FPR);
   assign rf_reg    = idx[RW-1:0];
   assign rf_elem   = elem[EW-1:0];
   assign rf_wdata  = mem_rdata;

   assign ctl_we    = fire && dir_q && ((sect == SEC_HDR) || (sect == SEC_PC));
   assign ctl_sel   = (sect == SEC_HDR) ? idx[2:0] : SEL_PC;
   assign ctl_wdata = mem_rdata;

   assign run_we    = fire && dir_q && (sect == SEC_RUN);
   assign run_elem  = elem[EW-1:0];
   assign run_wval  = mem_rdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= 1'b0;
         nxpr_q  <= '0;
         nfpr_q  <= '0;
         vl_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_MEM;
                  dir_q   <= cmd_restore;
                  if (!cmd_restore) begin
                     nxpr_q <= cur_nxpr;
                     nfpr_q <= cur_nfpr;
                     vl_q   <= cur_vl;
                  end
               end
            end
            ST_RFRD: state_q <= ST_MEM;
            ST_MEM: begin
               if (mem_ready) begin
                  if (dir_q && (sect == SEC_HDR)) begin
                     case (idx[2:0])
                        3'd0:    nxpr_q <= mem_rdata[31:0];
                        3'd1:    nfpr_q <= mem_rdata[31:0];
                        3'd3:    vl_q   <= mem_rdata[31:0];
                        default: ;
                     endcase
                  end
                  if (nsect == SEC_END)
                     state_q <= ST_FIN;
                  else if (!dir_q && ((nsect == SEC_XPR) || (nsect == SEC_FPR)))
                     state_q <= ST_RFRD;
                  else
                     state_q <= ST_MEM;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vctx_xfer_chk.sv
module vctx_xfer_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          priv_ok,
   input logic          busy,
   input logic          done,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic          mem_write,
   input logic [1:0]    mem_size,
   input logic [AW-1:0] mem_addr,
   input logic [63:0]   mem_wdata,
   input logic          ctl_we,
   input logic          rf_we,
   input logic          run_we,
   input logic          rf_re
);

   a_r1_refuse_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !priv_ok) |=> (!busy && !mem_valid));

   a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_size)
                                     && $stable(mem_write)));

   a_r9_hold_wdata: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready && mem_write) |=> $stable(mem_wdata));

   a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_valid && !rf_re && !done));

   a_r7_write_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we || rf_we || run_we) |-> (mem_valid && mem_ready && !mem_write));

   a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_we, rf_we, run_we}));

   a_r11_read_before_beat: assert property (@(posedge clk) disable iff (!rst_n)
      rf_re |=> (mem_valid && mem_write && !rf_re));

endmodule

bind vctx_xfer vctx_xfer_chk #(.AW(AW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .priv_ok   (priv_ok),
   .busy      (busy),
   .done      (done),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_write (mem_write),
   .mem_size  (mem_size),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .ctl_we    (ctl_we),
   .rf_we     (rf_we),
   .run_we    (run_we),
   .rf_re     (rf_re)
);

// File: tb/vctx_xfer_tb_top.sv
module vctx_xfer_tb_top;

   localparam int AW    = 16;
   localparam int NREG  = 8;
   localparam int MAXVL = 4;
   localparam int RW    = 3;
   localparam int EW    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic             cmd_valid = 1'b0, cmd_restore = 1'b0, priv_ok = 1'b0;
   logic [AW-1:0]    cmd_base = '0;
   logic             cmd_refused, busy, done;
   logic [31:0]      c_nxpr, c_nfpr, c_maxvl, c_vl, c_idx;
   logic [63:0]      c_pc;
   logic             ctl_we;
   logic [2:0]       ctl_sel;
   logic [63:0]      ctl_wdata;
   logic             rf_re, rf_we, rf_fp;
   logic [RW-1:0]    rf_reg;
   logic [EW-1:0]    rf_elem;
   logic [63:0]      rf_wdata, rd_q;
   logic [MAXVL-1:0] runf;
   logic             run_we, run_wval;
   logic [EW-1:0]    run_elem;
   logic             mem_valid, mem_write, mem_ready = 1'b0;
   logic [1:0]       mem_size;
   logic [AW-1:0]    mem_addr;
   logic [63:0]      mem_wdata, mem_rdata;

   logic [7:0]  mem  [0:4095];
   logic [63:0] xrf  [0:NREG-1][0:MAXVL-1];
   logic [63:0] frf  [0:NREG-1][0:MAXVL-1];
   logic [7:0]  lfsr = 8'hA5;

   int checks = 0, errors = 0;
   int txn_cnt = 0, addr_err = 0;
   logic [AW-1:0] exp_addr = '0;

   vctx_xfer #(.AW(AW), .NREG(NREG), .MAXVL(MAXVL)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_restore(cmd_restore),
      .cmd_base(cmd_base), .priv_ok(priv_ok), .cmd_refused(cmd_refused), .busy(busy),
      .done(done), .cur_nxpr(c_nxpr), .cur_nfpr(c_nfpr), .cur_maxvl(c_maxvl),
      .cur_vl(c_vl), .cur_idx(c_idx), .cur_pc(c_pc), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
      .ctl_wdata(ctl_wdata), .rf_re(rf_re), .rf_we(rf_we), .rf_fp(rf_fp), .rf_reg(rf_reg),
      .rf_elem(rf_elem), .rf_wdata(rf_wdata), .rf_rdata(rd_q), .run_flags(runf),
      .run_we(run_we), .run_elem(run_elem), .run_wval(run_wval), .mem_valid(mem_valid),
      .mem_write(mem_write), .mem_size(mem_size), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   function automatic int nbytes(logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 8;
   endfunction

   // stalling memory, ready changes away from the clock edge
   always @(negedge clk) begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready <= lfsr[1] | lfsr[4];
   end

   always_comb begin
      for (int b = 0; b < 8; b++)
         mem_rdata[8*b +: 8] = (b < nbytes(mem_size)) ? mem[(mem_addr + AW'(b)) & 16'h0FFF] : 8'h00;
   end

   always @(posedge clk) begin
      if (mem_valid && mem_ready) begin
         if (mem_addr != exp_addr) addr_err++;
         exp_addr = mem_addr + AW'(nbytes(mem_size)) + ((txn_cnt == 4) ? AW'(4) : AW'(0));
         txn_cnt++;
         if (mem_write)
            for (int b = 0; b < nbytes(mem_size); b++)
               mem[(mem_addr + AW'(b)) & 16'h0FFF] = mem_wdata[8*b +: 8];
      end
      if (rf_re) rd_q <= rf_fp ? frf[rf_reg][rf_elem] : xrf[rf_reg][rf_elem];
      if (rf_we) begin
         if (rf_fp) frf[rf_reg][rf_elem] = rf_wdata;
         else       xrf[rf_reg][rf_elem] = rf_wdata;
      end
      if (run_we) runf[run_elem] <= run_wval;
      if (ctl_we) begin
         case (ctl_sel)
            3'd0: c_nxpr  <= ctl_wdata[31:0];
            3'd1: c_nfpr  <= ctl_wdata[31:0];
            3'd2: c_maxvl <= ctl_wdata[31:0];
            3'd3: c_vl    <= ctl_wdata[31:0];
            3'd4: c_idx   <= ctl_wdata[31:0];
            default: c_pc <= ctl_wdata;
         endcase
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] rdm(int a, int n);
      logic [63:0] v = '0;
      for (int b = 0; b < n; b++) v[8*b +: 8] = mem[(a + b) & 12'hFFF];
      return v;
   endfunction

   task automatic wrm(int a, int n, logic [63:0] v);
      for (int b = 0; b < n; b++) mem[(a + b) & 12'hFFF] = v[8*b +: 8];
   endtask

   function automatic logic [63:0] xpat(int r, int e);
      return 64'h1000_0000_0000_0000 | (64'(r) << 16) | 64'(e) | 64'hA500_0000;
   endfunction

   function automatic logic [63:0] fpat(int r, int e);
      return 64'h2000_0000_0000_0000 | (64'(r) << 16) | 64'(e) | 64'h5A00_0000;
   endfunction

   task automatic fill_state(int nx, int nf, int vl);
      c_nxpr = 32'(nx); c_nfpr = 32'(nf); c_maxvl = 32'(MAXVL); c_vl = 32'(vl);
      c_idx = 32'd2; c_pc = 64'h0123_4567_89AB_CDEF;
      for (int r = 0; r < NREG; r++)
         for (int e = 0; e < MAXVL; e++) begin
            xrf[r][e] = xpat(r, e);
            frf[r][e] = fpat(r, e);
         end
   endtask

   task automatic clear_mem();
      for (int a = 0; a < 4096; a++) mem[a] = 8'hEE;
   endtask

   // issue a privileged command, optionally poke a second one mid-run, wait for done
   task automatic run_cmd(input logic restore, input int base, input bit poke);
      @(negedge clk);
      txn_cnt = 0; addr_err = 0; exp_addr = AW'(base);
      cmd_valid = 1'b1; cmd_restore = restore; priv_ok = 1'b1; cmd_base = AW'(base);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         cmd_valid = 1'b1; cmd_restore = ~restore; cmd_base = AW'(base + 16'h0800);
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      begin : wait_done
         for (int i = 0; i < 4000; i++) begin
            if (done) disable wait_done;
            @(negedge clk);
         end
         chk("R10 done timeout", 64'(done), 64'd1);
      end
      @(negedge clk);
      chk("R10 busy drops after done", 64'(busy), 64'd0);
   endtask

   task automatic t_reset();
      chk("R10 reset busy", 64'(busy), 64'd0);
      chk("R10 reset done", 64'(done), 64'd0);
      chk("R10 reset mem_valid", 64'(mem_valid), 64'd0);
   endtask

   task automatic t_refuse();
      txn_cnt = 0;
      @(negedge clk);
      cmd_valid = 1'b1; priv_ok = 1'b0; cmd_restore = 1'b0; cmd_base = 16'h0100;
      #1 chk("R1 refused pulse", 64'(cmd_refused), 64'd1);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R1 refused stays idle", 64'(busy), 64'd0);
      repeat (8) @(negedge clk);
      chk("R1 refused no beats", 64'(txn_cnt), 64'd0);
      chk("R1 refused no pulse when quiet", 64'(cmd_refused), 64'd0);
   endtask

   task automatic t_save_full();
      int a, bad;
      fill_state(4, 3, 3);
      runf = 4'b0101;
      clear_mem();
      run_cmd(1'b0, 16'h0100, 1'b1);
      a = 16'h0100;
      chk("R2 hdr nxpr",  rdm(a + 0, 4), 64'd4);
      chk("R2 hdr nfpr",  rdm(a + 4, 4), 64'd3);
      chk("R2 hdr maxvl", rdm(a + 8, 4), 64'(MAXVL));
      chk("R2 hdr vl",    rdm(a + 12, 4), 64'd3);
      chk("R2 hdr idx",   rdm(a + 16, 4), 64'd2);
      chk("R2 gap untouched", rdm(a + 20, 4), 64'h0000_0000_EEEE_EEEE);
      chk("R3 pc at +24", rdm(a + 24, 8), 64'h0123_4567_89AB_CDEF);
      a += 32; bad = 0;
      for (int r = 1; r < 4; r++)
         for (int e = 0; e < 3; e++) begin
            if (rdm(a, 8) !== xpat(r, e)) bad++;
            a += 8;
         end
      chk("R4 R11 integer data register-major", 64'(bad), 64'd0);
      bad = 0;
      for (int r = 0; r < 3; r++)
         for (int e = 0; e < 3; e++) begin
            if (rdm(a, 8) !== fpat(r, e)) bad++;
            a += 8;
         end
      chk("R5 R11 fp data register-major", 64'(bad), 64'd0);
      chk("R6 run byte 0", rdm(a, 1), 64'd1);
      chk("R6 run byte 1", rdm(a + 1, 1), 64'd0);
      chk("R6 run byte 2", rdm(a + 2, 1), 64'd1);
      chk("R6 nothing past end", rdm(a + 3, 1), 64'hEE);
      chk("R10 second command ignored", rdm(16'h0900, 4), 64'hEEEE_EEEE);
      chk("R9 beat count full save", 64'(txn_cnt), 64'd27);
      chk("R9 addresses advance by size", 64'(addr_err), 64'd0);
   endtask

   task automatic t_save_empty();
      fill_state(5, 2, 0);
      clear_mem();
      run_cmd(1'b0, 16'h0200, 1'b0);
      chk("R8 vl zero ends after pc", 64'(txn_cnt), 64'd6);
      chk("R8 vl zero no data", rdm(16'h0220, 1), 64'hEE);
      fill_state(1, 0, 2);
      runf = 4'b0010;
      clear_mem();
      run_cmd(1'b0, 16'h0200, 1'b0);
      chk("R8 only run section", 64'(txn_cnt), 64'd8);
      chk("R8 R6 run byte at +32", rdm(16'h0220, 2), 64'h0100);
      chk("R9 addresses advance empty", 64'(addr_err), 64'd0);
   endtask

   task automatic t_restore();
      int a;
      fill_state(8, 4, 4);
      runf = 4'b1110;
      for (int r = 0; r < NREG; r++)
         for (int e = 0; e < MAXVL; e++) begin
            xrf[r][e] = 64'hDEAD;
            frf[r][e] = 64'hBEEF;
         end
      clear_mem();
      a = 16'h0300;
      wrm(a + 0, 4, 64'd3); wrm(a + 4, 4, 64'd1); wrm(a + 8, 4, 64'd4);
      wrm(a + 12, 4, 64'd2); wrm(a + 16, 4, 64'd1);
      wrm(a + 24, 8, 64'hFEDC_BA98_7654_3210);
      a += 32;
      for (int r = 1; r < 3; r++)
         for (int e = 0; e < 2; e++) begin wrm(a, 8, xpat(r, e)); a += 8; end
      for (int e = 0; e < 2; e++) begin wrm(a, 8, fpat(0, e)); a += 8; end
      wrm(a, 1, 64'h01); wrm(a + 1, 1, 64'h00);
      run_cmd(1'b1, 16'h0300, 1'b0);
      chk("R7 ctl nxpr", 64'(c_nxpr), 64'd3);
      chk("R7 ctl nfpr", 64'(c_nfpr), 64'd1);
      chk("R7 ctl vl",   64'(c_vl), 64'd2);
      chk("R7 ctl idx",  64'(c_idx), 64'd1);
      chk("R7 ctl pc",   c_pc, 64'hFEDC_BA98_7654_3210);
      chk("R7 x1 e1", xrf[1][1], xpat(1, 1));
      chk("R7 x2 e0", xrf[2][0], xpat(2, 0));
      chk("R7 f0 e1", frf[0][1], fpat(0, 1));
      chk("R7 R4 x0 untouched", xrf[0][0], 64'hDEAD);
      chk("R7 bound from image: x1 e2 untouched", xrf[1][2], 64'hDEAD);
      chk("R7 bound from image: x3 untouched", xrf[3][0], 64'hDEAD);
      chk("R7 run flags", 64'(runf), 64'b1101);
      chk("R7 restore beat count", 64'(txn_cnt), 64'd14);
      chk("R9 restore addresses", 64'(addr_err), 64'd0);
   endtask

   initial begin
      rd_q = '0;
      fill_state(2, 1, 1);
      runf = '0;
      clear_mem();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_refuse();
      t_save_full();
      t_save_empty();
      t_restore();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule